// File: doc/BRIEF.md
# Host Interface Interrupt Controller

This block raises interrupt requests toward a processor core on behalf of a parallel host interface. It watches three sources. The first is a receive data register that the host has filled. The second is a transmit data register that the host has drained. The third is a command that the host posts through a command vector register. The processor side sees a control register and a status register. The control register holds one enable per source and two flags going out to the host. The status register shows the three pending conditions and two flags coming in from the host.

A host command carries a 7-bit routine number and a request bit. The block turns the routine number into a core vector address equal to twice that number. This lets the host start any of 128 handlers, including handlers that normally belong to other peripherals. The receive and transmit sources use fixed vector addresses, which are set as parameters. The block presents one request at a time on a request/acknowledge pair. Enabled sources that are pending together are served in a fixed order.

Top module: `hif_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0 and the command vector register reads 0. The status register reads 5'b00010: transmit-empty (bit 1) is set, and receive-full (bit 0), command pending (bit 2) and the host flags (bits 4:3) are clear. No request is raised.
- R2: Receive-full (status bit 0) is set by a host receive write and cleared by a processor receive read. If both occur in the same cycle, the flag ends up set.
- R3: Transmit-empty (status bit 1) is set by a host transmit read and cleared by a processor transmit write. If both occur in the same cycle, the flag ends up clear.
- R4: A source can raise a request only while its enable is set. The enables are control bit 0 for receive, bit 1 for transmit and bit 2 for host command. A pending source whose enable is clear raises nothing.
- R5: Bit 7 of the command vector register is the host command request flag and bits 6:0 hold the routine number. Status bit 2 follows the request flag. Both clear in the cycle after the core acknowledges a host command request.
- R6: A host command request presents a vector address equal to twice the routine number: routine 0x55 gives 0xAA and routine 0x7F gives 0xFE. Receive and transmit requests present their parameter addresses.
- R7: While the command request flag is set, host writes to the command vector register are ignored.
- R8: When several enabled sources are pending, the block serves receive-full first, then transmit-empty, then host command.
- R9: A request rises one cycle after its enabled pending condition is visible in the status register. It then keeps the same vector until acknowledged and drops in the cycle after the acknowledge. Acknowledging a receive or transmit request does not clear its data condition.
- R10: Control bits 4:3 drive the two flags going out to the host. Host flag writes appear at status bits 4:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ctl_we | input | 1 | Processor write strobe for the control register |
| cpu_ctl_wdata | input | 5 | Control write data: enables [2:0], outgoing flags [4:3] |
| cpu_ctl_q | output | 5 | Control register contents |
| cpu_stat_q | output | 5 | Status: receive-full [0], transmit-empty [1], command pending [2], host flags [4:3] |
| cpu_rx_rd | input | 1 | Processor read strobe of the receive data register |
| cpu_tx_wr | input | 1 | Processor write strobe of the transmit data register |
| host_rx_wr | input | 1 | Host write strobe of the receive data register |
| host_tx_rd | input | 1 | Host read strobe of the transmit data register |
| host_flag_we | input | 1 | Host write strobe for the incoming flags |
| host_flag_wdata | input | 2 | Incoming flag values |
| host_flags_out | output | 2 | Outgoing flags from the control register |
| host_cvr_we | input | 1 | Host write strobe for the command vector register |
| host_cvr_wdata | input | 8 | Command vector write data: request [7], routine [6:0] |
| host_cvr_q | output | 8 | Command vector register contents |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the presented request |
| irq_ack | input | 1 | Core acknowledge of the presented request |

## Verification
The assertions take for granted that the core raises irq_ack only while irq_req is high, and only for a single cycle per request. The handshake and command-clear properties rely on that. The bench keeps to this: every acknowledge is a one-cycle pulse driven after a request has been seen high. The bench changes the enables or clears data conditions only at points where the expected request sequence is still well defined, for example together with an acknowledge or while a request is being held.

// File: rtl/hif_irq_pkg.sv
package hif_irq_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_IW  = $clog2(NSRC);
  // source index is also the priority rank: lower index is served first
  localparam int SRC_RX  = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_CMD = 2;
endpackage

// File: rtl/hif_irq_ctlreg.sv
module hif_irq_ctlreg
  import hif_irq_pkg::*;
#(
  parameter int FLAG_W = 2,
  localparam int CTL_W = NSRC + FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              hflag_we,
  input  logic [FLAG_W-1:0] hflag_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [FLAG_W-1:0] hflag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      hflag_q <= '0;
    end else begin
      if (ctl_we)   ctl_q   <= ctl_wdata;
      if (hflag_we) hflag_q <= hflag_wdata;
    end
  end
endmodule

// File: rtl/hif_irq_datastat.sv
module hif_irq_datastat (
  input  logic clk,
  input  logic rst,
  input  logic host_rx_wr,
  input  logic cpu_rx_rd,
  input  logic host_tx_rd,
  input  logic cpu_tx_wr,
  output logic rx_full,
  output logic tx_empty
);
  // a fresh write into either data register wins over a same-cycle drain
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full  <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      if (host_rx_wr)     rx_full <= 1'b1;
      else if (cpu_rx_rd) rx_full <= 1'b0;
      if (cpu_tx_wr)       tx_empty <= 1'b0;
      else if (host_tx_rd) tx_empty <= 1'b1;
    end
  end
endmodule

// File: rtl/hif_irq_cmdvec.sv
module hif_irq_cmdvec #(
  parameter int VEC_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cvr_we,
  input  logic [VEC_W:0] cvr_wdata,
  input  logic           cmd_done,
  output logic [VEC_W:0] cvr_q
);
  logic busy;
  assign busy = cvr_q[VEC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cvr_q <= '0;
    end else if (busy) begin
      // routine number frozen until the core takes the command
      if (cmd_done) cvr_q[VEC_W] <= 1'b0;
    end else if (cvr_we) begin
      cvr_q <= cvr_wdata;
    end
  end
endmodule

// File: rtl/hif_irq_arb.sv
module hif_irq_arb
  import hif_irq_pkg::*;
#(
  parameter int VEC_W = 7,
  parameter logic [VEC_W:0] RX_ADDR = 'h60,
  parameter logic [VEC_W:0] TX_ADDR = 'h64,
  localparam int AW = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   armed,
  input  logic [VEC_W-1:0]  cmd_vec,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [AW-1:0]     irq_vec,
  output logic [SRC_IW-1:0] irq_src,
  output logic              cmd_done
);
  logic [AW-1:0]     src_addr [NSRC];
  logic              hit;
  logic [SRC_IW-1:0] sel;

  for (genvar g = 0; g < NSRC; g++) begin : g_addr
    if (g == SRC_CMD) begin : g_cmd
      assign src_addr[g] = {cmd_vec, 1'b0};
    end else if (g == SRC_RX) begin : g_rx
      assign src_addr[g] = RX_ADDR;
    end else begin : g_tx
      assign src_addr[g] = TX_ADDR;
    end
  end

  // fixed priority: lowest index wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (armed[i]) begin
        hit = 1'b1;
        sel = i[SRC_IW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_src <= '0;
    end else if (irq_req) begin
      if (irq_ack) irq_req <= 1'b0;
    end else if (hit) begin
      irq_req <= 1'b1;
      irq_vec <= src_addr[sel];
      irq_src <= sel;
    end
  end

  assign cmd_done = irq_req & irq_ack & (irq_src == SRC_IW'(SRC_CMD));
endmodule

// File: rtl/hif_irq_ctrl.sv
module hif_irq_ctrl
  import hif_irq_pkg::*;
#(
  parameter int VEC_W  = 7,
  parameter int FLAG_W = 2,
  parameter logic [VEC_W:0] RX_VEC_ADDR = 'h60,
  parameter logic [VEC_W:0] TX_VEC_ADDR = 'h64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_ctl_we,
  input  logic [NSRC+FLAG_W-1:0] cpu_ctl_wdata,
  output logic [NSRC+FLAG_W-1:0] cpu_ctl_q,
  output logic [NSRC+FLAG_W-1:0] cpu_stat_q,
  input  logic                   cpu_rx_rd,
  input  logic                   cpu_tx_wr,
  input  logic                   host_rx_wr,
  input  logic                   host_tx_rd,
  input  logic                   host_flag_we,
  input  logic [FLAG_W-1:0]      host_flag_wdata,
  output logic [FLAG_W-1:0]      host_flags_out,
  input  logic                   host_cvr_we,
  input  logic [VEC_W:0]         host_cvr_wdata,
  output logic [VEC_W:0]         host_cvr_q,
  output logic                   irq_req,
  output logic [VEC_W:0]         irq_vec,
  input  logic                   irq_ack
);
  localparam int CTL_W = NSRC + FLAG_W;

  logic [FLAG_W-1:0] hflag_q;
  logic              rx_full, tx_empty, cmd_pend, cmd_done;
  logic [NSRC-1:0]   pend;
  logic [SRC_IW-1:0] irq_src;

  hif_irq_ctlreg #(.FLAG_W(FLAG_W)) u_ctl (
    .clk(clk), .rst(rst),
    .ctl_we(cpu_ctl_we), .ctl_wdata(cpu_ctl_wdata),
    .hflag_we(host_flag_we), .hflag_wdata(host_flag_wdata),
    .ctl_q(cpu_ctl_q), .hflag_q(hflag_q)
  );

  hif_irq_datastat u_data (
    .clk(clk), .rst(rst),
    .host_rx_wr(host_rx_wr), .cpu_rx_rd(cpu_rx_rd),
    .host_tx_rd(host_tx_rd), .cpu_tx_wr(cpu_tx_wr),
    .rx_full(rx_full), .tx_empty(tx_empty)
  );

  hif_irq_cmdvec #(.VEC_W(VEC_W)) u_cvr (
    .clk(clk), .rst(rst),
    .cvr_we(host_cvr_we), .cvr_wdata(host_cvr_wdata),
    .cmd_done(cmd_done), .cvr_q(host_cvr_q)
  );

  assign cmd_pend = host_cvr_q[VEC_W];

  always_comb begin
    pend          = '0;
    pend[SRC_RX]  = rx_full;
    pend[SRC_TX]  = tx_empty;
    pend[SRC_CMD] = cmd_pend;
  end

  hif_irq_arb #(.VEC_W(VEC_W), .RX_ADDR(RX_VEC_ADDR), .TX_ADDR(TX_VEC_ADDR)) u_arb (
    .clk(clk), .rst(rst),
    .armed(pend & cpu_ctl_q[NSRC-1:0]),
    .cmd_vec(host_cvr_q[VEC_W-1:0]),
    .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src),
    .cmd_done(cmd_done)
  );

  assign cpu_stat_q     = {hflag_q, pend};
  assign host_flags_out = cpu_ctl_q[CTL_W-1:NSRC];
endmodule

// File: rtl/hif_irq_ctrl_chk.sv
module hif_irq_ctrl_chk
  import hif_irq_pkg::*;
#(
  parameter int VEC_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_req,
  input logic              irq_ack,
  input logic [VEC_W:0]    irq_vec,
  input logic [SRC_IW-1:0] irq_src,
  input logic [NSRC-1:0]   ctl_en,
  input logic [NSRC-1:0]   stat_pend,
  input logic [VEC_W:0]    host_cvr_q,
  input logic              host_rx_wr,
  input logic              cpu_rx_rd
);
  logic [NSRC-1:0] armed;
  logic            cmd_ack;
  assign armed   = ctl_en & stat_pend;
  assign cmd_ack = irq_req && irq_ack && (irq_src == SRC_IW'(SRC_CMD));

  assert_rx_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_rx_rd && !host_rx_wr |=> !stat_pend[SRC_RX]);

  assert_req_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> ((($past(armed)) >> irq_src) & NSRC'(1)) != '0);

  assert_cmd_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |=> !host_cvr_q[VEC_W] && !stat_pend[SRC_CMD]);

  assert_cmd_vec_double_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && irq_src == SRC_IW'(SRC_CMD)
      |-> irq_vec == {$past(host_cvr_q[VEC_W-1:0]), 1'b0});

  assert_cvr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    host_cvr_q[VEC_W] && !cmd_ack |=> $stable(host_cvr_q));

  assert_rx_over_rest_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && irq_src != SRC_IW'(SRC_RX) |-> !$past(armed[SRC_RX]));

  assert_tx_over_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && irq_src == SRC_IW'(SRC_CMD) |-> !$past(armed[SRC_TX]));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack |=> !irq_req);
endmodule

bind hif_irq_ctrl hif_irq_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst),
  .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec), .irq_src(irq_src),
  .ctl_en(cpu_ctl_q[hif_irq_pkg::NSRC-1:0]),
  .stat_pend(cpu_stat_q[hif_irq_pkg::NSRC-1:0]),
  .host_cvr_q(host_cvr_q), .host_rx_wr(host_rx_wr), .cpu_rx_rd(cpu_rx_rd)
);

// File: tb/sim_hif_irq_ctrl.sv
module sim_hif_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RX_A = 8'h60;
  localparam logic [7:0] TX_A = 8'h64;

  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_ctl_we, cpu_rx_rd, cpu_tx_wr, host_rx_wr, host_tx_rd;
  logic       host_flag_we, host_cvr_we, irq_ack;
  logic [4:0] cpu_ctl_wdata, cpu_ctl_q, cpu_stat_q;
  logic [1:0] host_flag_wdata, host_flags_out;
  logic [7:0] host_cvr_wdata, host_cvr_q, irq_vec;
  logic       irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hif_irq_ctrl #(.VEC_W(7), .FLAG_W(2), .RX_VEC_ADDR(RX_A), .TX_VEC_ADDR(TX_A)) u0 (
    .clk(clk), .rst(rst),
    .cpu_ctl_we(cpu_ctl_we), .cpu_ctl_wdata(cpu_ctl_wdata), .cpu_ctl_q(cpu_ctl_q),
    .cpu_stat_q(cpu_stat_q), .cpu_rx_rd(cpu_rx_rd), .cpu_tx_wr(cpu_tx_wr),
    .host_rx_wr(host_rx_wr), .host_tx_rd(host_tx_rd),
    .host_flag_we(host_flag_we), .host_flag_wdata(host_flag_wdata),
    .host_flags_out(host_flags_out),
    .host_cvr_we(host_cvr_we), .host_cvr_wdata(host_cvr_wdata), .host_cvr_q(host_cvr_q),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [4:0] d);
    cpu_ctl_we = 1'b1; cpu_ctl_wdata = d;
    step();
    cpu_ctl_we = 1'b0;
  endtask

  task automatic wr_cvr(input logic [7:0] d);
    host_cvr_we = 1'b1; host_cvr_wdata = d;
    step();
    host_cvr_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cpu_ctl_we = 0; cpu_ctl_wdata = '0; cpu_rx_rd = 0; cpu_tx_wr = 0;
    host_rx_wr = 0; host_tx_rd = 0; host_flag_we = 0; host_flag_wdata = '0;
    host_cvr_we = 0; host_cvr_wdata = '0; irq_ack = 0;
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 ctl", cpu_ctl_q, 5'b00000);
    check("R1 stat", cpu_stat_q, 5'b00010);
    check("R1 cvr", host_cvr_q, 8'h00);
    check("R1 req", irq_req, 1'b0);
    check("R1 flags_out", host_flags_out, 2'b00);
  endtask

  task automatic t_rxflag();
    host_rx_wr = 1; step(); host_rx_wr = 0;
    check("R2 rx set", cpu_stat_q[0], 1'b1);
    step();
    check("R4 rx masked", irq_req, 1'b0);
    cpu_rx_rd = 1; step(); cpu_rx_rd = 0;
    check("R2 rx clear", cpu_stat_q[0], 1'b0);
    host_rx_wr = 1; cpu_rx_rd = 1; step(); host_rx_wr = 0; cpu_rx_rd = 0;
    check("R2 rx both wins set", cpu_stat_q[0], 1'b1);
    cpu_rx_rd = 1; step(); cpu_rx_rd = 0;
    check("R2 rx clear again", cpu_stat_q[0], 1'b0);
  endtask

  task automatic t_txflag();
    cpu_tx_wr = 1; step(); cpu_tx_wr = 0;
    check("R3 tx clear", cpu_stat_q[1], 1'b0);
    host_tx_rd = 1; step(); host_tx_rd = 0;
    check("R3 tx set", cpu_stat_q[1], 1'b1);
    host_tx_rd = 1; cpu_tx_wr = 1; step(); host_tx_rd = 0; cpu_tx_wr = 0;
    check("R3 tx both wins clear", cpu_stat_q[1], 1'b0);
    host_tx_rd = 1; step(); host_tx_rd = 0;
    check("R3 tx restored", cpu_stat_q[1], 1'b1);
  endtask

  task automatic t_flags();
    wr_ctl(5'b11000);
    check("R10 flags out", host_flags_out, 2'b11);
    check("R10 ctl readback", cpu_ctl_q, 5'b11000);
    host_flag_we = 1; host_flag_wdata = 2'b01; step(); host_flag_we = 0;
    check("R10 host flags in", cpu_stat_q[4:3], 2'b01);
    wr_ctl(5'b01000);
    check("R10 flags out low", host_flags_out, 2'b01);
    check("R4 no req flags only", irq_req, 1'b0);
    host_flag_we = 1; host_flag_wdata = 2'b00; step(); host_flag_we = 0;
    wr_ctl(5'b00000);
  endtask

  task automatic t_cmd();
    wr_cvr(8'hD5);
    check("R5 cvr written", host_cvr_q, 8'hD5);
    check("R5 pending mirrors", cpu_stat_q[2], 1'b1);
    check("R4 cmd masked", irq_req, 1'b0);
    wr_cvr(8'h23);
    check("R7 write ignored", host_cvr_q, 8'hD5);
    wr_ctl(5'b00100);
    check("R9 not yet", irq_req, 1'b0);
    step();
    check("R9 cmd req", irq_req, 1'b1);
    check("R6 vec 0x55", irq_vec, 8'hAA);
    ack();
    check("R9 dropped", irq_req, 1'b0);
    check("R5 flag cleared", host_cvr_q, 8'h55);
    check("R5 pending cleared", cpu_stat_q[2], 1'b0);
    step();
    check("R5 no re-request", irq_req, 1'b0);
    wr_cvr(8'h23);
    check("R7 write accepted idle", host_cvr_q, 8'h23);
    step();
    check("R5 no flag no req", irq_req, 1'b0);
    wr_cvr(8'hFF);
    step();
    check("R6 max req", irq_req, 1'b1);
    check("R6 vec 0x7F", irq_vec, 8'hFE);
    ack();
    check("R5 cleared max", host_cvr_q, 8'h7F);
    wr_ctl(5'b00000);
  endtask

  task automatic t_prio();
    host_rx_wr = 1; step(); host_rx_wr = 0;
    wr_cvr(8'h81);
    wr_ctl(5'b00111);
    check("R8 idle before arb", irq_req, 1'b0);
    step();
    check("R8 rx first req", irq_req, 1'b1);
    check("R8 rx first vec", irq_vec, RX_A);
    irq_ack = 1; cpu_rx_rd = 1; step(); irq_ack = 0; cpu_rx_rd = 0;
    check("R9 drop after rx", irq_req, 1'b0);
    step();
    check("R8 tx second req", irq_req, 1'b1);
    check("R8 tx second vec", irq_vec, TX_A);
    irq_ack = 1; cpu_tx_wr = 1; step(); irq_ack = 0; cpu_tx_wr = 0;
    check("R9 drop after tx", irq_req, 1'b0);
    step();
    check("R8 cmd third req", irq_req, 1'b1);
    check("R8 cmd third vec", irq_vec, 8'h02);
    ack();
    check("R5 cmd cleared", cpu_stat_q[2], 1'b0);
    wr_ctl(5'b00000);
    host_tx_rd = 1; step(); host_tx_rd = 0;
    check("R3 tx refilled", cpu_stat_q[1], 1'b1);
  endtask

  task automatic t_hold();
    wr_ctl(5'b00001);
    host_rx_wr = 1; step(); host_rx_wr = 0;
    check("R9 one cycle latency", irq_req, 1'b0);
    step();
    check("R9 req up", irq_req, 1'b1);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R9 held", {irq_req, irq_vec}, {1'b1, RX_A});
    end
    cpu_rx_rd = 1; step(); cpu_rx_rd = 0;
    check("R9 held after read", irq_req, 1'b1);
    check("R2 rx cleared in hold", cpu_stat_q[0], 1'b0);
    ack();
    check("R9 drop", irq_req, 1'b0);
    step();
    check("R9 stays low", irq_req, 1'b0);
    host_rx_wr = 1; step(); host_rx_wr = 0;
    step();
    check("R9 req again", irq_req, 1'b1);
    ack();
    check("R9 drop keep data", irq_req, 1'b0);
    check("R9 rx not cleared by ack", cpu_stat_q[0], 1'b1);
    step();
    check("R9 re-request", irq_req, 1'b1);
    irq_ack = 1; cpu_rx_rd = 1; step(); irq_ack = 0; cpu_rx_rd = 0;
    step();
    check("R9 idle after read", irq_req, 1'b0);
    wr_ctl(5'b00000);
  endtask

  task automatic t_mask();
    host_rx_wr = 1; step(); host_rx_wr = 0;
    wr_cvr(8'h90);
    repeat (3) step();
    check("R4 all masked", irq_req, 1'b0);
    wr_ctl(5'b00010);
    step();
    check("R4 tx only req", irq_req, 1'b1);
    check("R4 tx only vec", irq_vec, TX_A);
    irq_ack = 1; cpu_ctl_we = 1; cpu_ctl_wdata = 5'b00000;
    step();
    irq_ack = 0; cpu_ctl_we = 0;
    step();
    check("R4 masked after disable", irq_req, 1'b0);
    cpu_rx_rd = 1; step(); cpu_rx_rd = 0;
    wr_ctl(5'b00100);
    step();
    check("R4 cmd enabled vec", irq_vec, 8'h20);
    ack();
    wr_ctl(5'b00000);
  endtask

  initial begin
    t_reset();
    t_rxflag();
    t_txflag();
    t_flags();
    t_cmd();
    t_prio();
    t_hold();
    t_mask();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule